// File: doc/BRIEF.md
# Serial Expansion Ring Controller

This block is the host end of a four-wire serial link to an expansion board made of cascaded shift registers. The four wires are a shift clock, a shared latch, serial data to the board and serial data from the board. The controller runs a repeating ring cycle with three steps. First it shifts a parallel output word into the board's serial-in/parallel-out chain. Next it holds the latch low for one shift-clock period. The return of the latch to high commits the new board outputs, and the low period parallel-loads the board's input pins into its parallel-in/serial-out chain. Finally it shifts that input word back into the controller.

The shift clock is derived from the system clock through a parameterised divider. Serial data out changes while the shift clock falls. Serial data in is sampled on the system edge that raises the shift clock. Each completed input word is published together with a one-cycle strobe. A presence flag is computed from that word: an all-zeros or all-ones capture means no board is attached, and the input vector then shows a configurable released value. One output bit, the tape motor enable, is sent with inverted polarity.

Top module: `exp_ring_ctrl`

## Requirements
- R1: During and directly after reset, the latch is high, the shift clock is low, `present` and `done` are low, and `in_word` shows the `IN_IDLE` value.
- R2: Each cycle sends exactly `OUT_BITS` data bits, most significant bit first. A board chain clocked on shift-clock rising edges therefore holds the sampled word in the same bit order when the latch rises.
- R3: The latch goes low together with the falling shift clock of the last output bit. It returns high together with the next falling shift clock. It is therefore low for exactly one shift-clock period, which is 2*`DIV` system clocks, once per cycle.
- R4: Every ring cycle has exactly `OUT_BITS`+`IN_BITS` shift-clock rising edges. Each shift-clock level lasts `DIV` system clocks.
- R5: The first serial bit received lands in bit `IN_BITS`-1 of `in_word`. After a cycle, `in_word` equals the board pins that were loaded while the latch was low.
- R6: `out_word` is sampled at the first falling shift clock of a cycle. A change made later in the cycle reaches the board only in the next cycle.
- R7: A captured word of all zeros or all ones clears `present`. While `present` is low, `in_word` shows `IN_IDLE` (all ones by default) in place of the captured bits.
- R8: Bit `MOTOR_POS` of `out_word` reaches the board inverted. All other bits reach the board unchanged.
- R9: `done` is high for exactly one system clock per cycle, in the same clock in which `in_word` and `present` take their new values.
- R10: `present` stays low after reset until the first full cycle has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_word | input | OUT_BITS | Parallel values for the board outputs |
| in_word | output | IN_BITS | Last captured board inputs, or IN_IDLE while absent |
| present | output | 1 | Board detected by the last completed capture |
| done | output | 1 | One-clock strobe when a new input word is published |
| ring_clk | output | 1 | Shift clock to the board |
| ring_latch | output | 1 | Shared latch / load line, resting high |
| ring_sdo | output | 1 | Serial data to the output chain |
| ring_sdi | input | 1 | Serial data from the input chain |

## Verification
The bench builds the block with the default 32-bit output chain, the 24-bit input chain, the motor bit at position 5 and `DIV` = 2. The short divider makes each ring cycle 224 system clocks, so many complete cycles fit in the run. It also keeps the latch window at exactly four system clocks, so an off-by-one in the latch placement or the chain lengths shows up directly in the behavioural board model: the output chain would commit shifted data, or the input chain would load at the wrong moment. Pin patterns that touch the edge bits, as well as all-zero and all-one captures, exercise bit ordering and presence detection.

// File: rtl/exp_ring_pkg.sv
package exp_ring_pkg;

   typedef enum logic {
      PH_SEND = 1'b0,
      PH_RECV = 1'b1
   } ring_phase_e;

endpackage

// File: rtl/exp_ring_tick.sv
module exp_ring_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic fall_evt,
   output logic rise_evt
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;
   logic          half;
   logic          evt;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("exp_ring_tick: DIV must be at least 2");
      end
   endgenerate

   assign evt      = (cnt == CW'(DIV - 1));
   assign fall_evt = evt && !half;
   assign rise_evt = evt && half;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         half <= 1'b0;
      end else if (evt) begin
         cnt  <= '0;
         half <= !half;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

endmodule

// File: rtl/exp_ring_seq.sv
module exp_ring_seq
   import exp_ring_pkg::*;
#(
   parameter int OUT_BITS  = 32,
   parameter int IN_BITS   = 24,
   parameter int MOTOR_POS = 5,
   parameter bit MOTOR_INV = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fall_evt,
   input  logic                rise_evt,
   input  logic [OUT_BITS-1:0] out_word,
   input  logic                bus_sdi,
   output logic                bus_clk,
   output logic                bus_latch,
   output logic                bus_sdo,
   output logic                word_valid,
   output logic [IN_BITS-1:0]  word
);
   localparam int MAXB = (OUT_BITS > IN_BITS) ? OUT_BITS : IN_BITS;
   localparam int CW   = $clog2(MAXB);
   localparam logic [CW-1:0] LAST_OUT = CW'(OUT_BITS - 1);
   localparam logic [CW-1:0] LAST_IN  = CW'(IN_BITS - 1);
   localparam logic [OUT_BITS-1:0] MOTOR_MASK =
      MOTOR_INV ? (OUT_BITS'(1) << MOTOR_POS) : '0;

   generate
      if (MOTOR_POS < 0 || MOTOR_POS >= OUT_BITS) begin : g_bad_motor
         $error("exp_ring_seq: MOTOR_POS outside the output word");
      end
      if (IN_BITS < 2 || OUT_BITS < 2) begin : g_bad_len
         $error("exp_ring_seq: chains need at least two bits");
      end
   endgenerate

   ring_phase_e         phase;
   logic [CW-1:0]       cnt;
   logic [OUT_BITS-1:0] hold;
   logic [IN_BITS-1:0]  rx;
   logic [OUT_BITS-1:0] src;

   assign src = out_word ^ MOTOR_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase      <= PH_SEND;
         cnt        <= '0;
         hold       <= '0;
         rx         <= '0;
         bus_clk    <= 1'b0;
         bus_latch  <= 1'b1;
         bus_sdo    <= 1'b0;
         word_valid <= 1'b0;
         word       <= '0;
      end else begin
         word_valid <= 1'b0;
         if (fall_evt) begin
            bus_clk <= 1'b0;
            if (phase == PH_SEND) begin
               if (cnt == '0) begin
                  bus_sdo <= src[OUT_BITS-1];
                  hold    <= src << 1;
               end else begin
                  bus_sdo <= hold[OUT_BITS-1];
                  hold    <= hold << 1;
               end
               if (cnt == LAST_OUT) bus_latch <= 1'b0;
            end else begin
               bus_latch <= 1'b1;
            end
         end
         if (rise_evt) begin
            bus_clk <= 1'b1;
            if (phase == PH_SEND) begin
               if (cnt == LAST_OUT) begin
                  cnt   <= '0;
                  phase <= PH_RECV;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end else begin
               rx <= {rx[IN_BITS-2:0], bus_sdi};
               if (cnt == LAST_IN) begin
                  cnt        <= '0;
                  phase      <= PH_SEND;
                  word_valid <= 1'b1;
                  word       <= {rx[IN_BITS-2:0], bus_sdi};
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
         end
      end
   end

   // R3
   latch_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_latch) |-> !bus_clk);

   // R3
   latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_latch) |-> $fell(bus_clk));

   // R4
   clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_clk) |=> bus_clk);

endmodule

// File: rtl/exp_ring_capture.sv
module exp_ring_capture #(
   parameter int                 IN_BITS = 24,
   parameter logic [IN_BITS-1:0] IN_IDLE = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_valid,
   input  logic [IN_BITS-1:0] word,
   output logic [IN_BITS-1:0] in_word,
   output logic               present,
   output logic               done
);
   logic [IN_BITS-1:0] raw;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw     <= '0;
         present <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= word_valid;
         if (word_valid) begin
            raw     <= word;
            present <= !((word == '0) || (word == '1));
         end
      end
   end

   assign in_word = present ? raw : IN_IDLE;

   // R7
   absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word == '0) |=> !present);

   // R7
   absent_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && word == '1) |=> (!present && in_word == IN_IDLE));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   present_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(present) |-> done);

endmodule

// File: rtl/exp_ring_ctrl.sv
module exp_ring_ctrl #(
   parameter int                 OUT_BITS  = 32,
   parameter int                 IN_BITS   = 24,
   parameter int                 DIV       = 2,
   parameter int                 MOTOR_POS = 5,
   parameter bit                 MOTOR_INV = 1'b1,
   parameter logic [IN_BITS-1:0] IN_IDLE   = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [OUT_BITS-1:0] out_word,
   output logic [IN_BITS-1:0]  in_word,
   output logic                present,
   output logic                done,
   output logic                ring_clk,
   output logic                ring_latch,
   output logic                ring_sdo,
   input  logic                ring_sdi
);
   logic               fall_evt;
   logic               rise_evt;
   logic               word_valid;
   logic [IN_BITS-1:0] word;

   exp_ring_tick #(.DIV(DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt)
   );

   exp_ring_seq #(
      .OUT_BITS  (OUT_BITS),
      .IN_BITS   (IN_BITS),
      .MOTOR_POS (MOTOR_POS),
      .MOTOR_INV (MOTOR_INV)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall_evt   (fall_evt),
      .rise_evt   (rise_evt),
      .out_word   (out_word),
      .bus_sdi    (ring_sdi),
      .bus_clk    (ring_clk),
      .bus_latch  (ring_latch),
      .bus_sdo    (ring_sdo),
      .word_valid (word_valid),
      .word       (word)
   );

   exp_ring_capture #(
      .IN_BITS (IN_BITS),
      .IN_IDLE (IN_IDLE)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (word_valid),
      .word       (word),
      .in_word    (in_word),
      .present    (present),
      .done       (done)
   );

endmodule

// File: tb/exp_ring_ctrl_tb.sv
module exp_ring_ctrl_tb;
   localparam int OB  = 32;
   localparam int IB  = 24;
   localparam int DIV = 2;
   localparam int MP  = 5;
   localparam logic [OB-1:0] MMASK = 32'h1 << MP;
   localparam logic [IB-1:0] IDLE  = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [OB-1:0] out_word = '0;
   logic [IB-1:0] in_word;
   logic          present, done, ring_clk, ring_latch, ring_sdo, ring_sdi;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // behavioural board model
   logic [OB-1:0] chain_out = '0;
   logic [OB-1:0] board_q   = '0;
   logic [IB-1:0] chain_in  = '0;
   logic [IB-1:0] pins      = '0;

   always #2 clk = !clk;

   exp_ring_ctrl #(.OUT_BITS(OB), .IN_BITS(IB), .DIV(DIV), .MOTOR_POS(MP)) u_dut (
      .clk(clk), .rst_n(rst_n), .out_word(out_word), .in_word(in_word),
      .present(present), .done(done), .ring_clk(ring_clk),
      .ring_latch(ring_latch), .ring_sdo(ring_sdo), .ring_sdi(ring_sdi)
   );

   always @(posedge ring_clk) begin
      chain_out <= {chain_out[OB-2:0], ring_sdo};
      if (!ring_latch) chain_in <= pins;
      else             chain_in <= {chain_in[IB-2:0], 1'b0};
   end
   always @(posedge ring_latch) board_q <= chain_out;
   assign ring_sdi = chain_in[IB-1];

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic wait_done();
      int n = 0;
      @(negedge clk);
      while (!done) begin
         @(negedge clk);
         n++;
         if (n > 2000) begin
            chk(1'b0, "R9 done timeout", 32'(n), 32'd0);
            finish_run();
         end
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "watchdog", 32'(cyc), 32'd0);
         finish_run();
      end
   end

   // per-clock monitors: R3 latch width, R4 rises per cycle, R9 strobe width
   int  low_cnt = 0;
   int  rises = 0;
   logic p_clk = 1'b0, p_latch = 1'b1, p_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!ring_latch) low_cnt++;
         if (ring_latch && !p_latch) begin
            chk(low_cnt == 2 * DIV, "R3 latch low width", 32'(low_cnt), 32'(2 * DIV));
            low_cnt = 0;
         end
         if (!ring_latch && p_latch)
            chk(!ring_clk, "R3 latch falls with clk low", 32'(ring_clk), 32'd0);
         if (ring_clk && !p_clk) rises++;
         if (done) begin
            chk(rises == OB + IB, "R4 rises per cycle", 32'(rises), 32'(OB + IB));
            rises = 0;
            chk(!p_done, "R9 done one clock", 32'(p_done), 32'd0);
         end
         p_clk   = ring_clk;
         p_latch = ring_latch;
         p_done  = done;
      end
   end

   initial begin
      logic [OB-1:0] a;
      out_word = 32'hC3A5_0F21;
      pins     = 24'h5AC31E;
      repeat (5) @(negedge clk);
      // R1
      chk(ring_latch && !ring_clk, "R1 latch/clk in reset", {30'd0, ring_latch, ring_clk}, 32'd2);
      chk(!present && !done, "R1 flags in reset", {30'd0, present, done}, 32'd0);
      chk(in_word == IDLE, "R1 in_word idle", 32'(in_word), 32'(IDLE));
      rst_n = 1'b1;
      @(negedge clk);
      chk(ring_latch && !ring_clk, "R1 after release", {30'd0, ring_latch, ring_clk}, 32'd2);
      // R10: absent until first cycle completes
      repeat (100) @(negedge clk);
      chk(!present, "R10 absent before first cycle", 32'(present), 32'd0);
      wait_done();
      chk(present, "R10 present after first cycle", 32'(present), 32'd1);
      chk(in_word == pins, "R5 first capture", 32'(in_word), 32'(pins));
      chk(board_q == (out_word ^ MMASK), "R2 first cycle outputs", board_q, out_word ^ MMASK);
      chk(board_q[MP] == !out_word[MP], "R8 motor inverted", 32'(board_q[MP]), 32'(!out_word[MP]));
      chk((board_q & ~MMASK) == (out_word & ~MMASK), "R8 other bits plain",
          board_q & ~MMASK, out_word & ~MMASK);

      // edge bits of input, different output pattern
      pins = 24'h800001;
      out_word = 32'h8000_0001;
      wait_done(); wait_done();
      chk(in_word == pins, "R5 edge bits", 32'(in_word), 32'(pins));
      chk(board_q == (out_word ^ MMASK), "R2 edge bits out", board_q, out_word ^ MMASK);
      chk(board_q[MP] == 1'b1, "R8 motor set when request low", 32'(board_q[MP]), 32'd1);

      out_word = 32'h0123_4567;
      pins = 24'h00F0F0;
      wait_done(); wait_done();
      chk(in_word == pins, "R5 pattern three", 32'(in_word), 32'(pins));
      chk(board_q == (out_word ^ MMASK), "R2 pattern three", board_q, out_word ^ MMASK);

      // R7 absence
      pins = '0;
      wait_done(); wait_done();
      chk(!present, "R7 all zeros absent", 32'(present), 32'd0);
      chk(in_word == IDLE, "R7 idle when zeros", 32'(in_word), 32'(IDLE));
      pins = '1;
      wait_done(); wait_done();
      chk(!present, "R7 all ones absent", 32'(present), 32'd0);
      chk(in_word == IDLE, "R7 idle when ones", 32'(in_word), 32'(IDLE));
      pins = 24'h000001;
      wait_done(); wait_done();
      chk(present, "R7 single one present", 32'(present), 32'd1);
      chk(in_word == pins, "R7 single one value", 32'(in_word), 32'(pins));
      pins = 24'hFFFFFE;
      wait_done(); wait_done();
      chk(present && in_word == pins, "R7 single zero present", 32'(in_word), 32'(pins));

      // R6 mid-cycle change
      out_word = 32'hDEAD_BEEF;
      wait_done();
      a = out_word;
      repeat (20) @(negedge clk);
      out_word = 32'h1357_9BDF;
      wait_done();
      chk(board_q == (a ^ MMASK), "R6 mid-cycle change deferred", board_q, a ^ MMASK);
      wait_done();
      chk(board_q == (out_word ^ MMASK), "R6 change applied next cycle", board_q, out_word ^ MMASK);

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule